// File: doc/BRIEF.md
# Phase-Selection QPSK Modulator

This block turns a serial stream of baseband bits into a one-bit QPSK square-wave signal. It never mixes or looks up a sine. A free-running three-bit counter divides the clock by eight and yields one square carrier with 50% duty. Three further copies of that carrier are shifted by a quarter period each. Incoming bits are paired into two-bit symbols, and each symbol picks one of the four copies for the output. The output is meant to drive an external D/A converter.

The block works only while `start` is high. When `start` drops, the output goes to 0 and the counter, the half-collected bit pair and the current symbol are all cleared. The next rising `start` therefore begins a fresh frame. Each symbol lasts one carrier period of eight clocks, so the block takes one serial bit every four clocks.

Top module: `qpsk_phase_mod`

## Requirements
- R1: After an active-low `rst_n` with `start` low, `mod_out` is 0.
- R2: While `start` is low, `mod_out` is 0. A low `start` clears the counter, the pending bit and the current symbol, so a later rising `start` behaves exactly like the first one after reset.
- R3: Counting rising edges with `start` high from 0, `din` is sampled only at edges 3 and 7 of every eight-edge frame. The bit sampled at edge 3 is the first bit and becomes the symbol MSB. The bit sampled at edge 7 is the second bit and becomes the symbol LSB. `din` at every other edge has no effect.
- R4: The base carrier has a period of 8 clocks. It is high for counter values 0..3 and low for 4..7. Carrier k (k = 0..3) is the base carrier delayed by 2k clocks, so it is high when (count - 2k) mod 8 is below 4.
- R5: The symbol selects the carrier as follows: 11 selects k=0 (45°), 01 selects k=1 (135°), 00 selects k=2 (225°) and 10 selects k=3 (315°).
- R6: A symbol is loaded only at the counter wrap from 7 to 0. It is then held for exactly 8 clocks.
- R7: During the first 8 clocks after `start` rises, no symbol has been loaded yet and `mod_out` is 0.
- R8: The serial input 10 11 00 01 10 11 10 00 00 00 produces the carrier phases 315°, 45°, 225°, 135°, 315°, 45°, 315°, 225°, 225°, 225°, in that order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the carrier runs at one eighth of its rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | High to run modulation; low to idle and clear |
| din | input | 1 | Serial baseband bit, sampled every fourth clock |
| mod_out | output | 1 | One-bit modulated square wave |

## Verification
The hardest case to reach is a `start` drop in the middle of a frame while a first bit is pending and a symbol is on the output, followed by a restart that must show no trace of either. The bench stops a stream at an odd counter value, checks the idle output and then replays a fresh sequence against the model from the first edge. It also drives random values on `din` at every edge where the block should not sample. A wrong sampling point or bit order therefore changes the waveform.

// File: rtl/qpsk_phase_mod.sv
module qpsk_phase_mod (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic din,
  output logic mod_out
);
  localparam int CW = 3;
  localparam logic [CW-1:0] FIRST_AT = CW'(3);
  localparam logic [CW-1:0] LAST_AT  = CW'(7);

  logic [CW-1:0] cnt;
  logic          a_bit;
  logic [1:0]    sym;
  logic          sym_valid;
  logic [1:0]    k;
  logic [CW-1:0] rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; a_bit <= 1'b0; sym <= 2'b00; sym_valid <= 1'b0;
    end else if (!start) begin
      cnt <= '0; a_bit <= 1'b0; sym <= 2'b00; sym_valid <= 1'b0;
    end else begin
      cnt <= cnt + CW'(1);
      if (cnt == FIRST_AT) a_bit <= din;
      if (cnt == LAST_AT) begin
        sym       <= {a_bit, din};
        sym_valid <= 1'b1;
      end
    end
  end

  always_comb begin
    case (sym)
      2'b11:   k = 2'd0;
      2'b01:   k = 2'd1;
      2'b00:   k = 2'd2;
      default: k = 2'd3;
    endcase
  end

  assign rel     = cnt - {k, 1'b0};
  assign mod_out = start & sym_valid & ~rel[CW-1];

  assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |-> !mod_out);
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && $past(start)) |-> cnt == CW'($past(cnt) + CW'(1)));
  assert_half_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && sym_valid && cnt >= CW'(4)) |-> mod_out != $past(mod_out, 4));
  assert_sym_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $stable(sym));
  assert_fresh_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start) |-> !sym_valid && cnt == '0);
endmodule

// File: tb/qpsk_phase_mod_bench.sv
module qpsk_phase_mod_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, din = 1'b0;
  logic mod_out;
  int total = 0, bad = 0;
  int gbits [64];
  int gn = 0;

  always #5 clk = ~clk;

  qpsk_phase_mod u_qpsk_phase_mod (.clk(clk), .rst_n(rst_n), .start(start), .din(din), .mod_out(mod_out));

  function automatic int getbit(int i);
    return (i < gn) ? gbits[i] : 0;
  endfunction

  function automatic int phase_deg(int a, int b);
    if (a == 1 && b == 1) return 45;
    if (a == 0 && b == 1) return 135;
    if (a == 0 && b == 0) return 225;
    return 315;
  endfunction

  function automatic logic wave(int deg, int c);
    int kk = (deg - 45) / 90;
    return (((c - 2 * kk) % 8 + 8) % 8) < 4;
  endfunction

  task automatic check(logic got, logic exp, string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: mod_out=%0b expected=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic run_seq(int edges, string tag);
    start = 1'b1;
    check(mod_out, 1'b0, "R7");
    for (int e = 0; e < edges; e++) begin
      din = (e % 4 == 3) ? 1'(getbit(e / 4)) : 1'($urandom_range(0, 1));
      @(posedge clk);
      @(negedge clk);
      begin
        int m = e + 1;
        int p = m / 8 - 1;
        if (p < 0) check(mod_out, 1'b0, "R7");
        else check(mod_out, wave(phase_deg(getbit(2 * p), getbit(2 * p + 1)), m % 8), tag);
      end
    end
  endtask

  task automatic idle(int n);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      din = 1'($urandom_range(0, 1));
      @(posedge clk);
      @(negedge clk);
      check(mod_out, 1'b0, "R2");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not complete");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int stated [20] = '{1,0,1,1,0,0,0,1,1,0,1,1,1,0,0,0,0,0,0,0};
    repeat (3) @(negedge clk);
    check(mod_out, 1'b0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    check(mod_out, 1'b0, "R1");

    gn = 20;
    for (int i = 0; i < 20; i++) gbits[i] = stated[i];
    run_seq(4 * 20 + 8, "R8 R5 R3 R6");
    idle(6);

    gn = 40;
    for (int i = 0; i < 40; i++) gbits[i] = $urandom_range(0, 1);
    run_seq(45, "R5 R4");
    idle(5);

    gn = 32;
    for (int i = 0; i < 32; i++) gbits[i] = $urandom_range(0, 1);
    run_seq(4 * 32 + 8, "R2 R3 R4 R5 R6");
    idle(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule